// File: doc/BRIEF.md
# SPI Controller Register Front End

This block is the software-facing half of a master SPI controller. It decodes 32-bit word accesses to five registers (receive data port, transmit data port, control, interrupt enable, status) and holds the transmit and receive FIFOs. It derives the status flags from FIFO occupancy and keeps two sticky events. It drives one level-sensitive interrupt and the active-low chip selects. A separate serial engine takes words from the head of the transmit FIFO through a valid/ready pair. It returns received words through a push strobe, reports the end of a transfer with a one-cycle pulse, and reads its configuration from the control register output.

The enable bit gates the block. While it is clear, every register write except one to the control register is dropped, and engine traffic is ignored. Writing the control register with the enable bit clear is a soft reset: the written value is kept, and everything else returns to its reset state. A hard reset also clears the control register.

Top module: `spi_reg_front`

## Requirements
- R1: While control bit 0 (enable) is 0, writes to any register other than control have no effect, the engine sees no transmit data (`eng_tx_valid_o` low), and engine pushes and done pulses are ignored.
- R2: A control write with bit 0 at 0 stores the written value and clears the interrupt enables and both sticky status bits. It empties both FIFOs and drives every chip select high from the next cycle.
- R3: After any reset the status register reads 0x00000003. Its bit layout is: 0 transmit empty, 1 transmit has room (not full), 2 transmit full, 3 receive ready (not empty), 4 receive full, 5 receive overflow, 6 transfer complete.
- R4: Only status bits 5 and 6 respond to writes, and writing 1 clears them. Writing other bits changes nothing.
- R5: Status bits 0 to 4 follow FIFO occupancy each cycle. Bit 6 is set by an `eng_done_i` pulse while enabled.
- R6: `irq_o` is high exactly when the status register AND the interrupt enable register (bits 6:0) is nonzero.
- R7: A read of word 0 (receive port) pops and returns the oldest received word. If the receive FIFO is empty, the read returns 0xDEADBEEF and pops nothing.
- R8: A write to word 1 (transmit port) while the transmit FIFO is full is discarded. Reads of word 1 return 0. The engine receives transmit words in write order.
- R9: An engine push into a full receive FIFO drops the word and sets status bit 5.
- R10: The register map is word 0 receive, 1 transmit, 2 control, 3 interrupt enable, 4 status. Word addresses 5 and above read 0, and writes to them are ignored.
- R11: A hard reset (`rst_ni` low) clears the control register, in addition to everything the soft reset clears.
- R12: While enabled, the chip select numbered by control bits [4 + log2(NUM_CS) - 1 : 4] is low and all others are high. While disabled, all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| ctrl_o | output | 32 | Control register contents for the serial engine |
| eng_tx_valid_o | output | 1 | Transmit FIFO head available to the engine |
| eng_tx_data_o | output | 32 | Transmit FIFO head word |
| eng_tx_ready_i | input | 1 | Engine takes the head word |
| eng_rx_valid_i | input | 1 | Engine pushes a received word |
| eng_rx_data_i | input | 32 | Received word |
| eng_done_i | input | 1 | Transfer complete pulse |
| cs_n_o | output | NUM_CS | Active-low chip selects |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with FIFO_DEPTH set to 4 and NUM_CS left at 4. With that depth, transmit-full, the discarded fifth write, receive-full and receive overflow all occur within a handful of accesses. Four chip selects let a mid-range and the top select index be checked against the all-high disabled pattern. The default ADDR_W of 10 keeps a far out-of-range word address (1023) reachable alongside the first unmapped word.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned NUM_REGS  = 5;

  typedef enum logic [REG_IDX_W-1:0] {
    IDX_RXD  = 3'd0,
    IDX_TXD  = 3'd1,
    IDX_CTRL = 3'd2,
    IDX_IEN  = 3'd3,
    IDX_STAT = 3'd4
  } reg_idx_e;

  localparam int unsigned ST_W        = 7;
  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_CS_LSB = 4;

  localparam logic [ST_W-1:0] ST_RESET      = 7'h03;
  localparam logic [31:0]     RX_EMPTY_WORD = 32'hDEAD_BEEF;

  // Packed msb first: field order is the status bit order.
  typedef struct packed {
    logic xfer_done;
    logic rx_ovf;
    logic rx_full;
    logic rx_ready;
    logic tx_full;
    logic tx_room;
    logic tx_empty;
  } stat_t;

endpackage

// File: rtl/spi_reg_fifo.sv
module spi_reg_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem_q[wr_ptr_q] <= data_i;
  end

  // R8
  fifo_full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o && !pop_i && !clr_i |=> full_o && (data_o == $past(data_o)));

  // R2
  fifo_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);

endmodule

// File: rtl/spi_reg_status.sv
module spi_reg_status
  import spi_regs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            tx_empty_i,
  input  logic            tx_full_i,
  input  logic            rx_empty_i,
  input  logic            rx_full_i,
  input  logic            ovf_set_i,
  input  logic            done_set_i,
  input  logic            w1c_we_i,
  input  logic            w1c_ovf_i,
  input  logic            w1c_done_i,
  input  logic [ST_W-1:0] ien_i,
  output stat_t           stat_o,
  output logic            irq_o
);

  logic ovf_q, done_q;

  // Set wins over a same-cycle clear by software.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ovf_q  <= ovf_set_i  || (ovf_q  && !(w1c_we_i && w1c_ovf_i));
      done_q <= done_set_i || (done_q && !(w1c_we_i && w1c_done_i));
    end
  end

  always_comb begin
    stat_o           = '0;
    stat_o.tx_empty  = tx_empty_i;
    stat_o.tx_room   = !tx_full_i;
    stat_o.tx_full   = tx_full_i;
    stat_o.rx_ready  = !rx_empty_i;
    stat_o.rx_full   = rx_full_i;
    stat_o.rx_ovf    = ovf_q;
    stat_o.xfer_done = done_q;
  end

  assign irq_o = |(stat_o & ien_i);

  // R4
  ovf_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w1c_we_i && w1c_ovf_i && !ovf_set_i |=> !stat_o.rx_ovf);

  // R4
  done_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w1c_we_i && w1c_done_i && !done_set_i |=> !stat_o.xfer_done);

endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
  import spi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned NUM_CS     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [31:0]       ctrl_o,
  output logic              eng_tx_valid_o,
  output logic [31:0]       eng_tx_data_o,
  input  logic              eng_tx_ready_i,
  input  logic              eng_rx_valid_i,
  input  logic [31:0]       eng_rx_data_i,
  input  logic              eng_done_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              irq_o
);

  localparam int unsigned CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [31:0]     ctrl_q, rdata_q, rd_val, rx_head;
  logic [ST_W-1:0] ien_q, stat_vec;
  stat_t           stat;
  reg_idx_e        idx;
  logic            in_map, en, wr_any, wr_ctrl, wr_on, soft_rst;
  logic            tx_empty, tx_full, rx_empty, rx_full;
  logic            tx_push, tx_pop, rx_push, rx_pop, ovf_set;
  logic [CS_W-1:0] cs_sel;

  assign in_map   = (reg_addr_i < ADDR_W'(NUM_REGS));
  assign idx      = reg_idx_e'(reg_addr_i[REG_IDX_W-1:0]);
  assign en       = ctrl_q[CTRL_EN_BIT];
  assign wr_any   = reg_we_i && in_map;
  assign wr_ctrl  = wr_any && (idx == IDX_CTRL);
  assign wr_on    = wr_any && en;
  assign soft_rst = wr_ctrl && !reg_wdata_i[CTRL_EN_BIT];

  assign tx_push  = wr_on && (idx == IDX_TXD);
  assign tx_pop   = en && eng_tx_ready_i;
  assign rx_push  = en && eng_rx_valid_i;
  assign rx_pop   = reg_re_i && in_map && (idx == IDX_RXD);
  assign ovf_set  = rx_push && rx_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i;
      if (soft_rst)                         ien_q <= '0;
      else if (wr_on && (idx == IDX_IEN))   ien_q <= reg_wdata_i[ST_W-1:0];
    end
  end

  spi_reg_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_rst),
    .push_i  (tx_push),
    .data_i  (reg_wdata_i),
    .pop_i   (tx_pop),
    .data_o  (eng_tx_data_o),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  spi_reg_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_rst),
    .push_i  (rx_push),
    .data_i  (eng_rx_data_i),
    .pop_i   (rx_pop),
    .data_o  (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  spi_reg_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (soft_rst),
    .tx_empty_i (tx_empty),
    .tx_full_i  (tx_full),
    .rx_empty_i (rx_empty),
    .rx_full_i  (rx_full),
    .ovf_set_i  (ovf_set),
    .done_set_i (en && eng_done_i),
    .w1c_we_i   (wr_on && (idx == IDX_STAT)),
    .w1c_ovf_i  (reg_wdata_i[5]),
    .w1c_done_i (reg_wdata_i[6]),
    .ien_i      (ien_q),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  assign stat_vec = stat;

  always_comb begin
    rd_val = '0;
    if (in_map) begin
      case (idx)
        IDX_RXD:  rd_val = rx_empty ? RX_EMPTY_WORD : rx_head;
        IDX_CTRL: rd_val = ctrl_q;
        IDX_IEN:  rd_val = 32'(ien_q);
        IDX_STAT: rd_val = 32'(stat_vec);
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_val;
  end

  assign reg_rdata_o    = rdata_q;
  assign ctrl_o         = ctrl_q;
  assign eng_tx_valid_o = en && !tx_empty;
  assign cs_sel         = ctrl_q[CTRL_CS_LSB +: CS_W];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n_o[g] = !(en && (cs_sel == CS_W'(g)));
  end

  // R2
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (stat_vec == ST_RESET) && (ien_q == '0) && (&cs_n_o));

  // R9
  rx_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push && rx_full && !soft_rst |=> stat.rx_ovf);

  // R1
  gated_ien_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en && reg_we_i && in_map && (idx == IDX_IEN) |=> $stable(ien_q));

  // R7
  rx_empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop && rx_empty |=> (reg_rdata_o == RX_EMPTY_WORD));

endmodule

// File: tb/spi_reg_front_tb.sv
`timescale 1ns/1ps
module spi_reg_front_tb;

  localparam int unsigned AW  = 10;
  localparam int unsigned NCS = 4;

  localparam logic [AW-1:0] A_RXD = 10'd0, A_TXD = 10'd1, A_CTRL = 10'd2,
                            A_IEN = 10'd3, A_STAT = 10'd4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           we = 1'b0, re = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata, ctrl;
  logic           tx_valid, tx_ready = 1'b0;
  logic [31:0]    tx_data;
  logic           rx_valid = 1'b0, done = 1'b0;
  logic [31:0]    rx_data = '0;
  logic [NCS-1:0] cs_n;
  logic           irq;

  int n_chk = 0, n_bad = 0;
  bit ended = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  spi_reg_front #(.ADDR_W(AW), .FIFO_DEPTH(4), .NUM_CS(NCS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ctrl_o(ctrl),
    .eng_tx_valid_o(tx_valid), .eng_tx_data_o(tx_data), .eng_tx_ready_i(tx_ready),
    .eng_rx_valid_i(rx_valid), .eng_rx_data_i(rx_data), .eng_done_i(done),
    .cs_n_o(cs_n), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // Scoreboard monitor: a read issued before an edge is compared at the next negedge.
  always @(posedge clk) rd_seen <= re;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); re = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic eng_pop(input logic [31:0] exp);
    @(negedge clk); tx_ready = 1'b1;
    chk("R8 tx order", tx_data, exp);
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic eng_push(input logic [31:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic eng_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk("R12 cs idle", 32'(cs_n), 32'hF);
    chk("R6 irq idle", 32'(irq), 0);
    rd(A_STAT, 32'h3, "R3 reset status");
    rd(A_CTRL, 32'h0, "R11 reset ctrl");
    // gating while disabled
    wr(A_IEN, 32'h7F);
    wr(A_TXD, 32'h11);
    rd(A_IEN, 32'h0, "R1 ien gated");
    chk("R1 irq gated", 32'(irq), 0);
    // enable, select cs 2
    wr(A_CTRL, 32'h21);
    chk("R12 cs sel2", 32'(cs_n), 32'hB);
    chk("R1 tx write dropped", 32'(tx_valid), 0);
    rd(A_CTRL, 32'h21, "R10 ctrl readback");
    // transmit fill and drain
    wr(A_TXD, 32'hA1); wr(A_TXD, 32'hA2);
    chk("R8 tx valid", 32'(tx_valid), 1);
    rd(A_STAT, 32'h2, "R5 tx partial");
    wr(A_TXD, 32'hA3); wr(A_TXD, 32'hA4);
    rd(A_STAT, 32'h4, "R5 tx full");
    wr(A_TXD, 32'hA5);
    rd(A_TXD, 32'h0, "R8 tx port reads 0");
    for (int i = 1; i <= 4; i++) eng_pop(32'hA0 + 32'(i));
    chk("R8 full write discarded", 32'(tx_valid), 0);
    rd(A_STAT, 32'h3, "R5 tx drained");
    // receive path
    rd(A_RXD, 32'hDEADBEEF, "R7 empty read");
    rd(A_STAT, 32'h3, "R7 empty read no pop");
    for (int i = 1; i <= 3; i++) eng_push(32'hB0 + 32'(i));
    rd(A_STAT, 32'hB, "R5 rx ready");
    eng_push(32'hB4);
    rd(A_STAT, 32'h1B, "R5 rx full");
    eng_push(32'hB5);
    rd(A_STAT, 32'h3B, "R9 overflow flag");
    for (int i = 1; i <= 4; i++) rd(A_RXD, 32'hB0 + 32'(i), "R7 rx order");
    rd(A_RXD, 32'hDEADBEEF, "R9 overflow word dropped");
    rd(A_STAT, 32'h23, "R9 overflow sticky");
    // interrupt and write-one-to-clear
    wr(A_IEN, 32'h20);
    chk("R6 irq ovf", 32'(irq), 1);
    wr(A_STAT, 32'h1F);
    rd(A_STAT, 32'h23, "R4 non-w1c bits");
    wr(A_STAT, 32'h20);
    chk("R4 irq after clear", 32'(irq), 0);
    rd(A_STAT, 32'h3, "R4 ovf cleared");
    eng_done();
    rd(A_STAT, 32'h43, "R5 done sets tc");
    chk("R6 irq masked", 32'(irq), 0);
    wr(A_IEN, 32'h40);
    chk("R6 irq tc", 32'(irq), 1);
    wr(A_STAT, 32'h40);
    chk("R4 tc cleared irq", 32'(irq), 0);
    wr(A_IEN, 32'h01);
    chk("R6 irq tx empty", 32'(irq), 1);
    wr(A_IEN, 32'h0);
    // unmapped words
    wr(10'd5, 32'hFFFF_FFFF);
    rd(10'd5, 32'h0, "R10 unmapped read");
    rd(10'd1023, 32'h0, "R10 far unmapped read");
    rd(A_IEN, 32'h0, "R10 no alias");
    // soft reset
    wr(A_TXD, 32'hC1);
    eng_push(32'hD1);
    wr(A_IEN, 32'h08);
    chk("R6 irq rx ready", 32'(irq), 1);
    wr(A_CTRL, 32'h30);
    chk("R2 cs all high", 32'(cs_n), 32'hF);
    chk("R2 irq cleared", 32'(irq), 0);
    chk("R2 tx flushed", 32'(tx_valid), 0);
    rd(A_CTRL, 32'h30, "R2 ctrl kept");
    rd(A_IEN, 32'h0, "R2 ien cleared");
    rd(A_STAT, 32'h3, "R2 status reset");
    rd(A_RXD, 32'hDEADBEEF, "R2 rx flushed");
    // engine and writes ignored while disabled
    wr(A_TXD, 32'hF1);
    eng_push(32'hF2);
    eng_done();
    wr(A_CTRL, 32'h31);
    chk("R12 cs sel3", 32'(cs_n), 32'h7);
    chk("R1 tx gated", 32'(tx_valid), 0);
    rd(A_STAT, 32'h3, "R1 engine ignored");
    // hard reset
    wr(A_TXD, 32'hE1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R11 tx cleared", 32'(tx_valid), 0);
    chk("R11 cs high", 32'(cs_n), 32'hF);
    rd(A_CTRL, 32'h0, "R11 ctrl cleared");
    rd(A_STAT, 32'h3, "R11 status reset");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule